// File: doc/BRIEF.md
# Performance Counter Overflow Status Unit

This unit keeps a small bank of 40-bit event counters. The general-purpose counters come first and the fixed-function counters follow. Every overflow is gathered into one 64-bit status word, and that word drives a level-sensitive interrupt request. Each counter adds one for every cycle in which its event input and its enable input are both high. When a counter passes from all ones to zero it wraps and keeps counting, and the wrap sets the counter's status bit.

Any general counter can be switched into precise-sampling mode. In that mode a wrap still sets the counter's status bit. It also raises a per-counter record-store request, which stays high until the matching acknowledge arrives. In the acknowledge cycle the unit clears the counter's own status bit and sets the shared sample-buffer flag. A one-cycle configuration-change pulse sets a separate condition-changed flag.

Software reaches the unit through a synchronous register port:

| Address | Register | Access |
|---|---|---|
| 0 to 4 | Counters, in bank order | Read and load |
| 8 | Status word | Read only |
| 9 | Overflow-clear | Write only |

The overflow-clear register uses the same bit layout as the status word. A 1 in a bit position clears the matching status bit.

Top module: `pmu_ovf_status`

## Requirements
- R1: After reset every counter reads 0, the status word reads 0, the interrupt output is low and no record-store request is raised.
- R2: A counter adds one on each clock edge at which its event input and its enable input are both high. With its enable low, the counter holds its value.
- R3: When an event arrives at a counter holding all ones (0xFF_FFFF_FFFF), the counter wraps to 0 and counting continues from there. The same edge sets the counter's status bit: bit 0 or bit 1 for the general counters, and bit 32, 33 or 34 for the fixed counters at addresses 2, 3 and 4.
- R4: Reserved status bits (2 to 31 and 35 to 61) always read 0. Writing the clear register with 1s only in reserved positions, or with 0s in the used positions, leaves the status word unchanged.
- R5: A write to the clear register at address 9 clears every status bit whose position holds a 1, and any mix of bits can be cleared in a single write.
- R6: When a status bit is set and cleared in the same cycle, the set wins and the bit reads 1.
- R7: The interrupt output is high exactly when the interrupt-enable input is high and at least one used status bit is 1.
- R8: A one-cycle pulse on the configuration-change input sets status bit 63 at the following edge.
- R9: When a general counter in precise-sampling mode wraps, its status bit is set and its record-store request rises at the same edge. The request stays high until acknowledged.
- R10: At the edge where a raised record-store request is acknowledged, the counter's status bit is cleared, status bit 62 is set and the request falls.
- R11: A register write to a counter address loads the low 40 bits of the write data. The load takes priority over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 5 | Per-counter count enable, general counters first |
| event_in | input | 5 | Per-counter event pulse |
| precise_en | input | 2 | Precise-sampling mode select for each general counter |
| cfg_change | input | 1 | Configuration-change pulse that sets the condition-changed flag |
| irq_en | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for the current address |
| store_req | output | 2 | Record-store request for each general counter |
| store_ack | input | 2 | Record-store acknowledge for each general counter |
| pmi_irq | output | 1 | Level interrupt request |

## Verification
Two cases are hard to reach from the ports, because they need particular events to coincide in a single cycle.

The first is a status bit that is set and cleared in the same cycle. To reach it, the stimulus first loads a counter with all ones through the register port. It then drives the counter's event input in the same cycle as a clear write that targets that counter's bit.

The second is the deferred status update in precise mode. The stimulus makes a precise counter wrap and then keeps the record-store request waiting for several cycles. During the wait the counter's own bit must stay set. The stimulus then acknowledges the request, and the own bit must move to the buffer flag at that edge.

// File: rtl/pmu_ovf_pkg.sv
package pmu_ovf_pkg;
   localparam int STAT_W   = 64;
   localparam int FIX_BASE = 32;
   localparam int BUF_BIT  = 62;
   localparam int CHG_BIT  = 63;

   typedef logic [STAT_W-1:0] stat_t;

   // status position of counter idx (general counters first)
   function automatic int stat_pos(int idx, int ng);
      return (idx < ng) ? idx : FIX_BASE + idx - ng;
   endfunction

   function automatic stat_t valid_mask(int ng, int nf);
      stat_t m;
      m = '0;
      for (int i = 0; i < ng + nf; i++) m[stat_pos(i, ng)] = 1'b1;
      m[BUF_BIT] = 1'b1;
      m[CHG_BIT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
   parameter int CNT_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             event_in,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic             inc;

   assign inc   = cnt_en & event_in;
   assign wrap  = inc & ~load & (&cnt_q);
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (inc)  cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/pmu_precise_ctl.sv
module pmu_precise_ctl #(
   parameter int NUM_GEN = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GEN-1:0] wrap,
   input  logic [NUM_GEN-1:0] mode,
   input  logic [NUM_GEN-1:0] ack,
   output logic [NUM_GEN-1:0] req,
   output logic [NUM_GEN-1:0] done
);
   for (genvar g = 0; g < NUM_GEN; g++) begin : g_lane
      logic req_q;
      always_ff @(posedge clk) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= (req_q & ~ack[g]) | (wrap[g] & mode[g]);
      end
      assign req[g]  = req_q;
      assign done[g] = req_q & ack[g];
   end
endmodule

// File: rtl/pmu_status_reg.sv
module pmu_status_reg
   import pmu_ovf_pkg::*;
#(
   parameter stat_t VALID = '1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  stat_t set_vec,
   input  stat_t clr_vec,
   output stat_t status
);
   stat_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= ((st_q & ~clr_vec) | set_vec) & VALID;
   end
   assign status = st_q;
endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status
   import pmu_ovf_pkg::*;
#(
   parameter int NUM_GEN = 2,
   parameter int NUM_FIX = 3,
   parameter int CNT_W   = 40,
   parameter int ADDR_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_GEN+NUM_FIX-1:0] cnt_en,
   input  logic [NUM_GEN+NUM_FIX-1:0] event_in,
   input  logic [NUM_GEN-1:0]         precise_en,
   input  logic                       cfg_change,
   input  logic                       irq_en,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [STAT_W-1:0]          reg_wdata,
   output logic [STAT_W-1:0]          reg_rdata,
   output logic [NUM_GEN-1:0]         store_req,
   input  logic [NUM_GEN-1:0]         store_ack,
   output logic                       pmi_irq
);
   localparam int          NUM_CNT     = NUM_GEN + NUM_FIX;
   localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(2 ** (ADDR_W - 1));
   localparam logic [ADDR_W-1:0] ADDR_CLEAR  = ADDR_W'(2 ** (ADDR_W - 1) + 1);
   localparam stat_t       VALID       = valid_mask(NUM_GEN, NUM_FIX);

   if (CNT_W < 2 || CNT_W > STAT_W) begin : g_bad_width
      $error("CNT_W must lie in 2..64");
   end
   if (NUM_GEN < 1 || NUM_GEN > FIX_BASE) begin : g_bad_gen
      $error("NUM_GEN must lie in 1..32");
   end
   if (NUM_FIX < 1 || NUM_FIX > BUF_BIT - FIX_BASE) begin : g_bad_fix
      $error("NUM_FIX must lie in 1..30");
   end
   if (NUM_CNT > 2 ** (ADDR_W - 1)) begin : g_bad_addr
      $error("ADDR_W too small for the counter bank");
   end

   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
   logic [NUM_CNT-1:0]            wrap_vec;
   logic [NUM_GEN-1:0]            done_vec;
   stat_t                         set_vec, clr_vec, status_q;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic ld;
      assign ld = reg_wr && (reg_addr == ADDR_W'(i));
      pmu_event_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt_en   (cnt_en[i]),
         .event_in (event_in[i]),
         .load     (ld),
         .load_val (reg_wdata[CNT_W-1:0]),
         .count    (cnt_val[i]),
         .wrap     (wrap_vec[i])
      );
   end

   pmu_precise_ctl #(.NUM_GEN(NUM_GEN)) u_precise (
      .clk   (clk),
      .rst_n (rst_n),
      .wrap  (wrap_vec[NUM_GEN-1:0]),
      .mode  (precise_en),
      .ack   (store_ack),
      .req   (store_req),
      .done  (done_vec)
   );

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      for (int i = 0; i < NUM_CNT; i++) set_vec[stat_pos(i, NUM_GEN)] = wrap_vec[i];
      set_vec[BUF_BIT] = |done_vec;
      set_vec[CHG_BIT] = cfg_change;
      if (reg_wr && reg_addr == ADDR_CLEAR) clr_vec = reg_wdata;
      for (int g = 0; g < NUM_GEN; g++) clr_vec[g] = clr_vec[g] | done_vec[g];
   end

   pmu_status_reg #(.VALID(VALID)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .status  (status_q)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++)
         if (reg_addr == ADDR_W'(i)) reg_rdata = STAT_W'(cnt_val[i]);
      if (reg_addr == ADDR_STATUS) reg_rdata = status_q;
   end

   assign pmi_irq = irq_en & (|status_q);
endmodule

// File: rtl/pmu_ovf_checker.sv
module pmu_ovf_checker
   import pmu_ovf_pkg::*;
#(
   parameter int NUM_GEN = 2,
   parameter int NUM_FIX = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_GEN+NUM_FIX-1:0] wrap_vec,
   input stat_t                      status_q,
   input logic [NUM_GEN-1:0]         store_req,
   input logic [NUM_GEN-1:0]         store_ack,
   input logic                       cfg_change,
   input logic                       irq_en,
   input logic                       pmi_irq
);
   localparam stat_t VALID = valid_mask(NUM_GEN, NUM_FIX);

   p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~VALID) == '0);

   p_cfg_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> status_q[CHG_BIT]);

   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !pmi_irq);

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pmi_irq |-> (status_q != '0));

   for (genvar i = 0; i < NUM_GEN + NUM_FIX; i++) begin : g_wrap
      p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
         wrap_vec[i] |=> status_q[stat_pos(i, NUM_GEN)]);
   end

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_req
      p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (store_req[g] && !store_ack[g]) |=> store_req[g]);
      p_ack_buffer_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (store_req[g] && store_ack[g]) |=> status_q[BUF_BIT]);
      p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (store_req[g] && store_ack[g] && !wrap_vec[g]) |=> !store_req[g]);
   end
endmodule

bind pmu_ovf_status pmu_ovf_checker #(.NUM_GEN(NUM_GEN), .NUM_FIX(NUM_FIX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wrap_vec   (wrap_vec),
   .status_q   (status_q),
   .store_req  (store_req),
   .store_ack  (store_ack),
   .cfg_change (cfg_change),
   .irq_en     (irq_en),
   .pmi_irq    (pmi_irq)
);

// File: tb/pmu_ovf_status_test.sv
`timescale 1ns/1ps
module pmu_ovf_status_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cnt_en = '0, event_in = '0;
   logic [1:0]  precise_en = '0, store_ack = '0, store_req;
   logic        cfg_change = 1'b0, irq_en = 1'b0, reg_wr = 1'b0, pmi_irq;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0, reg_rdata;

   localparam logic [63:0] ONES40 = 64'h0000_00FF_FFFF_FFFF;
   localparam logic [63:0] B32 = 64'h0000_0001_0000_0000;
   localparam logic [63:0] B34 = 64'h0000_0004_0000_0000;
   localparam logic [63:0] B62 = 64'h4000_0000_0000_0000;
   localparam logic [63:0] B63 = 64'h8000_0000_0000_0000;

   always #5 clk = ~clk;

   pmu_ovf_status uut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .event_in(event_in),
      .precise_en(precise_en), .cfg_change(cfg_change), .irq_en(irq_en),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .store_req(store_req), .store_ack(store_ack),
      .pmi_irq(pmi_irq)
   );

   typedef struct {
      int          kind;   // 0 read data, 1 interrupt, 2 request vector
      logic [63:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int compared = 0, mismatched = 0;
   bit finished = 1'b0;

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [63:0] act;
         it = sb.pop_front();
         case (it.kind)
            0:       act = reg_rdata;
            1:       act = {63'd0, pmi_irq};
            default: act = {62'd0, store_req};
         endcase
         compared++;
         if (act !== it.exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_item(input int kind, input logic [3:0] addr,
                              input logic [63:0] exp, input string tag);
      item_t it;
      if (kind == 0) reg_addr = addr;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] addr, input logic [63:0] data);
      reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] mask, input int n);
      event_in = mask;
      repeat (n) @(posedge clk);
      #1 event_in = '0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_item(0, 4'd8, 64'd0, "R1 status after reset");
      expect_item(0, 4'd0, 64'd0, "R1 counter0 after reset");
      expect_item(1, 4'd0, 64'd0, "R1 irq after reset");
      expect_item(2, 4'd0, 64'd0, "R1 request after reset");

      cnt_en = 5'b11111;
      pulse(5'b11111, 5);
      expect_item(0, 4'd4, 64'd5, "R2 counter4 counts events");
      cnt_en[1] = 1'b0;
      pulse(5'b11111, 3);
      expect_item(0, 4'd0, 64'd8, "R2 enabled counter keeps counting");
      expect_item(0, 4'd1, 64'd5, "R2 disabled counter holds");
      cnt_en = 5'b11111;

      wr(4'd2, 64'h1234);
      expect_item(0, 4'd2, 64'h1234, "R11 counter load");
      event_in[3] = 1'b1;
      wr(4'd3, 64'h77);
      event_in = '0;
      expect_item(0, 4'd3, 64'h77, "R11 load beats event");

      wr(4'd2, ONES40);
      pulse(5'b00100, 1);
      expect_item(0, 4'd2, 64'd0, "R3 fixed counter wraps to zero");
      expect_item(0, 4'd8, B32, "R3 fixed0 status bit32");
      expect_item(1, 4'd0, 64'd0, "R7 irq masked by enable");
      irq_en = 1'b1;
      expect_item(1, 4'd0, 64'd1, "R7 irq with enable");
      pulse(5'b00100, 1);
      expect_item(0, 4'd2, 64'd1, "R3 counting continues after wrap");

      wr(4'd9, 64'h3FFF_FFF8_FFFF_FFFC);
      expect_item(0, 4'd8, B32, "R4 reserved clear ignored");

      wr(4'd0, ONES40);
      wr(4'd4, ONES40);
      pulse(5'b10001, 1);
      expect_item(0, 4'd8, B32 | B34 | 64'd1, "R3 general0 and fixed2 wrap");
      wr(4'd9, B34 | 64'd1);
      expect_item(0, 4'd8, B32, "R5 multi-bit clear");
      wr(4'd9, B32);
      expect_item(0, 4'd8, 64'd0, "R5 last bit cleared");
      expect_item(1, 4'd0, 64'd0, "R7 irq drops with empty status");

      wr(4'd1, ONES40);
      event_in[1] = 1'b1;
      wr(4'd9, 64'd2);
      event_in = '0;
      expect_item(0, 4'd8, 64'd2, "R6 set beats clear");
      wr(4'd9, 64'd2);
      expect_item(0, 4'd8, 64'd0, "R6 later clear works");

      cfg_change = 1'b1;
      @(posedge clk); #1 cfg_change = 1'b0;
      expect_item(0, 4'd8, B63, "R8 condition-changed flag");
      expect_item(1, 4'd0, 64'd1, "R7 irq from bit63");
      wr(4'd9, B63);

      precise_en = 2'b01;
      wr(4'd0, ONES40);
      pulse(5'b00001, 1);
      expect_item(0, 4'd8, 64'd1, "R9 own bit set while pending");
      expect_item(2, 4'd0, 64'd1, "R9 request raised");
      repeat (3) @(posedge clk);
      #1;
      expect_item(2, 4'd0, 64'd1, "R9 request held without ack");
      expect_item(0, 4'd8, 64'd1, "R9 own bit still set");
      store_ack = 2'b01;
      @(posedge clk); #1 store_ack = '0;
      expect_item(2, 4'd0, 64'd0, "R10 request drops on ack");
      expect_item(0, 4'd8, B62, "R10 own bit moved to buffer flag");
      expect_item(1, 4'd0, 64'd1, "R7 irq from bit62");
      wr(4'd9, B62);
      expect_item(0, 4'd8, 64'd0, "R5 buffer flag cleared");

      repeat (2) @(posedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule